// File: doc/BRIEF.md
# Discontinuous-Mode ADC Group Sequencer

This block steps an analog-to-digital converter through a programmed list of channel numbers, a few channels at a time. The list holds up to `MAX_LEN` entries, of which the first `seq_len` are used, and it is cut into consecutive groups of `grp_size` channels. Each trigger pulse converts exactly one group, back to back. The block then goes idle and waits for the next trigger. The last group is shorter whenever the length is not a multiple of the group size. The trigger after the last group starts again from the first one, so the sequence repeats for as long as triggers keep coming.

The block drives a simple converter core: a channel select, a one-cycle start pulse, and a done strobe that returns the data. Every finished conversion produces a one-cycle end-of-conversion strobe that carries the result and the channel number, so a downstream mover can collect the results one by one in list order. An end-of-sequence strobe marks the final channel of the list. A trigger that arrives while a group is still running does not start anything; it only raises a sticky overrun flag. Dropping the enable aborts the group in progress and returns the sequence to its first group.

Top module: `adc_disc_seq`

## Requirements
- R1: After reset, adc_start, eoc, eos, busy and ovr_flag are 0, and the first accepted trigger converts list entry 0.
- R2: When a trigger is sampled high while enable is 1 and busy is 0, adc_start is 1 for exactly one cycle, beginning on the cycle after the trigger, with adc_ch equal to the list entry at the current sequence position; busy is 1 from that cycle until the group ends. List entry i is ch_list[i*CH_W +: CH_W].
- R3: Within a group, the next adc_start is issued on the cycle after adc_done, with adc_ch equal to the next list entry. A group holds grp_size conversions unless it is cut short by the end of the list.
- R4: When seq_len is not a multiple of grp_size, the final group converts only the remaining seq_len mod grp_size entries, then the block goes idle.
- R5: eoc is 1 for one cycle, on the cycle after each adc_done accepted while busy. It carries eoc_data equal to adc_data and eoc_ch equal to the channel that was converted.
- R6: eos is 1 together with the eoc of list entry seq_len-1, and is 0 otherwise.
- R7: The trigger after the final group converts the group that begins at list entry 0.
- R8: A trigger that arrives while busy and enable are 1 starts no conversion and produces no extra eoc. It sets ovr_flag on the following cycle, and the flag stays set until it is cleared.
- R9: ovr_clr=1 clears ovr_flag on the next cycle. If a new overrun happens in the same cycle, the set wins and the flag stays 1.
- R10: While enable is 0, busy goes to 0 on the next cycle. Triggers and adc_done are ignored, and the sequence position returns to list entry 0.
- R11: With grp_size >= seq_len, one trigger converts the whole list. With grp_size = 1, each trigger converts one entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Synchronous enable; 0 aborts and rewinds |
| trig | input | 1 | Trigger pulse; each accepted pulse converts one group |
| ovr_clr | input | 1 | Write-1 clear of the overrun flag |
| seq_len | input | LEN_W | Number of list entries used (1..MAX_LEN) |
| grp_size | input | LEN_W | Channels per group (1..MAX_LEN) |
| ch_list | input | MAX_LEN*CH_W | Packed channel list, entry i at bits i*CH_W |
| adc_done | input | 1 | Converter finished; adc_data is valid |
| adc_data | input | DATA_W | Converter result |
| adc_start | output | 1 | One-cycle start pulse to the converter |
| adc_ch | output | CH_W | Channel select for the converter |
| eoc | output | 1 | End-of-conversion strobe |
| eoc_data | output | DATA_W | Result that goes with eoc |
| eoc_ch | output | CH_W | Channel number that goes with eoc |
| eos | output | 1 | End-of-sequence strobe, coincident with the last eoc |
| busy | output | 1 | A group is being converted |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The sequencer is run with a five-entry list in groups of two. This shows that the groups really split, that the partial final group ends on its own, and that the fourth trigger wraps to the start. A group size larger than the list shows that one trigger covers the whole list. A group size of one shows that each trigger advances by a single entry. Triggers sent in the middle of a group, with and without a simultaneous clear, separate the overrun being ignored from the set-over-clear priority. A mid-group enable drop, with the converter answering after the drop, shows that the late result is discarded and the position is rewound.

// File: rtl/adc_disc_seq.sv
module adc_disc_seq #(
  parameter int MAX_LEN = 8,
  parameter int CH_W    = 5,
  parameter int DATA_W  = 12,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int POS_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    trig,
  input  logic                    ovr_clr,
  input  logic [LEN_W-1:0]        seq_len,
  input  logic [LEN_W-1:0]        grp_size,
  input  logic [MAX_LEN*CH_W-1:0] ch_list,
  input  logic                    adc_done,
  input  logic [DATA_W-1:0]       adc_data,
  output logic                    adc_start,
  output logic [CH_W-1:0]         adc_ch,
  output logic                    eoc,
  output logic [DATA_W-1:0]       eoc_data,
  output logic [CH_W-1:0]         eoc_ch,
  output logic                    eos,
  output logic                    busy,
  output logic                    ovr_flag
);

  logic [CH_W-1:0]  lane [MAX_LEN];
  logic [POS_W-1:0] pos;
  logic [LEN_W-1:0] gcnt;
  logic             conv;

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_lane
    assign lane[i] = ch_list[i*CH_W +: CH_W];
  end

  wire [LEN_W-1:0] pos_inc  = LEN_W'(pos) + LEN_W'(1);
  wire             last_seq = pos_inc >= seq_len;
  wire             last_grp = (gcnt + LEN_W'(1)) >= grp_size;
  wire [POS_W-1:0] pos_next = last_seq ? '0 : pos_inc[POS_W-1:0];
  wire             go       = enable && trig && !conv;
  wire             fin      = enable && conv && adc_done;
  wire             ovr_set  = enable && trig && conv;

  assign busy = conv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv      <= 1'b0;
      pos       <= '0;
      gcnt      <= '0;
      adc_start <= 1'b0;
      adc_ch    <= '0;
      eoc       <= 1'b0;
      eoc_data  <= '0;
      eoc_ch    <= '0;
      eos       <= 1'b0;
      ovr_flag  <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      eoc       <= 1'b0;
      eos       <= 1'b0;
      if (ovr_set)      ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
      if (!enable) begin
        conv <= 1'b0;
        pos  <= '0;
        gcnt <= '0;
      end else if (go) begin
        conv      <= 1'b1;
        gcnt      <= '0;
        adc_start <= 1'b1;
        adc_ch    <= lane[pos];
      end else if (fin) begin
        eoc      <= 1'b1;
        eoc_data <= adc_data;
        eoc_ch   <= adc_ch;
        eos      <= last_seq;
        pos      <= pos_next;
        if (last_grp || last_seq) begin
          conv <= 1'b0;
          gcnt <= '0;
        end else begin
          gcnt      <= gcnt + LEN_W'(1);
          adc_start <= 1'b1;
          adc_ch    <= lane[pos_next];
        end
      end
    end
  end

endmodule

// File: rtl/adc_disc_seq_chk.sv
module adc_disc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic trig,
  input logic ovr_clr,
  input logic adc_done,
  input logic adc_start,
  input logic eoc,
  input logic eos,
  input logic busy,
  input logic ovr_flag
);

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);

  assert_eoc_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $past(adc_done));

  assert_eos_with_eoc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> eoc);

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig && enable) |=> ovr_flag);

  assert_overrun_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !(busy && trig && enable)) |=> !ovr_flag);

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !adc_start && !eoc));

endmodule

bind adc_disc_seq adc_disc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .trig(trig), .ovr_clr(ovr_clr),
  .adc_done(adc_done), .adc_start(adc_start), .eoc(eoc), .eos(eos),
  .busy(busy), .ovr_flag(ovr_flag)
);

// File: tb/adc_disc_seq_bench.sv
module adc_disc_seq_bench;
  localparam int MAX_LEN = 8;
  localparam int CH_W    = 5;
  localparam int DATA_W  = 12;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic clk = 0, rst_n = 0, enable = 0, trig = 0, ovr_clr = 0;
  logic [LEN_W-1:0] seq_len = 5, grp_size = 2;
  logic [MAX_LEN*CH_W-1:0] ch_list;
  logic adc_done = 0;
  logic [DATA_W-1:0] adc_data = 0;
  logic adc_start, eoc, eos, busy, ovr_flag;
  logic [CH_W-1:0] adc_ch, eoc_ch;
  logic [DATA_W-1:0] eoc_data;

  int chans [MAX_LEN] = '{3, 7, 1, 12, 9, 20, 5, 30};
  int errors = 0, checks = 0;
  int bpos = 0, group_left = 0;
  logic [CH_W:0] expq [$];
  logic [3:0] lat_cnt = 0;
  logic [CH_W-1:0] m_ch = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < MAX_LEN; i++) ch_list[i*CH_W +: CH_W] = CH_W'(chans[i]);

  adc_disc_seq #(.MAX_LEN(MAX_LEN), .CH_W(CH_W), .DATA_W(DATA_W)) u_adc_disc_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trig(trig), .ovr_clr(ovr_clr),
    .seq_len(seq_len), .grp_size(grp_size), .ch_list(ch_list),
    .adc_done(adc_done), .adc_data(adc_data), .adc_start(adc_start),
    .adc_ch(adc_ch), .eoc(eoc), .eoc_data(eoc_data), .eoc_ch(eoc_ch),
    .eos(eos), .busy(busy), .ovr_flag(ovr_flag));

  function automatic logic [DATA_W-1:0] fdata(input int ch);
    return DATA_W'(ch * 131 + 7);
  endfunction

  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (adc_start) begin
      lat_cnt <= 4'd3;
      m_ch    <= adc_ch;
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 4'd1;
      if (lat_cnt == 4'd1) begin
        adc_done <= 1'b1;
        adc_data <= fdata(int'(m_ch));
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && eoc) begin
      if (expq.size() == 0) begin
        chk(0, "R8/R10 unexpected eoc", int'(eoc_ch), -1);
      end else begin
        logic [CH_W:0] it;
        it = expq.pop_front();
        chk(eoc_ch == it[CH_W-1:0], "R5 eoc_ch", int'(eoc_ch), int'(it[CH_W-1:0]));
        chk(eoc_data == fdata(int'(it[CH_W-1:0])), "R5 eoc_data", int'(eoc_data),
            int'(fdata(int'(it[CH_W-1:0]))));
        chk(eos == it[CH_W], "R6 eos", int'(eos), int'(it[CH_W]));
        group_left--;
        chk(adc_start == (group_left > 0), "R3 R4 back-to-back start", int'(adc_start),
            int'(group_left > 0));
        if (group_left > 0)
          chk(adc_ch == expq[0][CH_W-1:0], "R3 next channel", int'(adc_ch),
              int'(expq[0][CH_W-1:0]));
      end
    end
  end

  task automatic push_group();
    int n = int'(grp_size);
    if (bpos + n > int'(seq_len)) n = int'(seq_len) - bpos;
    for (int k = 0; k < n; k++)
      expq.push_back({(bpos + k == int'(seq_len) - 1), CH_W'(chans[bpos + k])});
    group_left = n;
    bpos = (bpos + n >= int'(seq_len)) ? 0 : bpos + n;
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
  endtask

  task automatic wait_group();
    int t = 0;
    while (group_left > 0 && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(group_left == 0, "R3 group completes", group_left, 0);
    repeat (2) @(negedge clk);
    chk(busy == 0, "R4 idle after group", int'(busy), 0);
  endtask

  task automatic run_group(input string req);
    int first;
    first = chans[bpos];
    push_group();
    pulse_trig();
    chk(adc_start == 1, {req, " start"}, int'(adc_start), 1);
    chk(int'(adc_ch) == first, {req, " first channel"}, int'(adc_ch), first);
    wait_group();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(adc_start == 0 && eoc == 0 && eos == 0, "R1 strobes idle", int'(adc_start | eoc | eos), 0);
    chk(busy == 0 && ovr_flag == 0, "R1 busy/ovr", int'(busy | ovr_flag), 0);
    enable = 1;
    @(negedge clk);

    run_group("R1 R2 group1");
    run_group("R2 group2");
    run_group("R4 group3");
    run_group("R7 wrap");
    run_group("R7 g2");
    run_group("R7 g3");

    push_group();
    pulse_trig();
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
    chk(ovr_flag == 1, "R8 overrun set", int'(ovr_flag), 1);
    wait_group();
    chk(ovr_flag == 1, "R8 overrun sticky", int'(ovr_flag), 1);

    push_group();
    pulse_trig();
    @(negedge clk) begin trig = 1; ovr_clr = 1; end
    @(negedge clk) begin trig = 0; ovr_clr = 0; end
    chk(ovr_flag == 1, "R9 set wins over clear", int'(ovr_flag), 1);
    wait_group();
    @(negedge clk) ovr_clr = 1;
    @(negedge clk) ovr_clr = 0;
    chk(ovr_flag == 0, "R9 clear", int'(ovr_flag), 0);

    pulse_trig();
    chk(adc_start == 1, "R10 group begins before abort", int'(adc_start), 1);
    @(negedge clk) enable = 0;
    @(negedge clk);
    chk(busy == 0, "R10 abort", int'(busy), 0);
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
    chk(adc_start == 0, "R10 trig ignored while disabled", int'(adc_start), 0);
    repeat (6) @(negedge clk);
    chk(busy == 0 && eoc == 0, "R10 stays idle", int'(busy | eoc), 0);
    enable = 1;
    bpos = 0;
    @(negedge clk);
    run_group("R10 rewind");

    @(negedge clk) enable = 0;
    @(negedge clk) begin grp_size = 8; enable = 1; end
    bpos = 0;
    @(negedge clk);
    run_group("R11 whole list");
    run_group("R11 whole list again");

    @(negedge clk) enable = 0;
    @(negedge clk) begin grp_size = 1; seq_len = 3; enable = 1; end
    bpos = 0;
    @(negedge clk);
    for (int g = 0; g < 4; g++) run_group("R11 single");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R5 all results seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule